// File: doc/BRIEF.md
# Register Valid-Bit Scoreboard

This block keeps one full/empty flag per architectural register and decides, each cycle, whether the instruction waiting in decode may leave it. A register becomes empty when an instruction that will write it is accepted out of decode, and becomes full again when that writer reports completion. A candidate instruction is held in decode while any register it reads is empty. Once no source it reads is empty, it goes.

The decode-to-execute boundary is a valid/ready handshake. Decode raises `iss_valid` with the candidate's sources, their enables, its destination and its write flag. The scoreboard answers with `iss_ready`, and the instruction counts as issued only in a cycle where both are high. `iss_ready` depends only on the stored flags and on the presented sources. Decode may therefore look at it before asserting `iss_valid`, and it may change its offer in any cycle in which the instruction is not accepted. The completion strobe carries no back-pressure: the block always takes it.

Top module: `reg_scoreboard`

## Requirements
- R1: After reset every register is full, so `iss_ready` is 1 for any source numbers and enables.
- R2: In a cycle with `iss_valid`, `iss_ready` and `iss_wr_en` all 1, the register named by `iss_dst` is empty from the next cycle.
- R3: In a cycle with `cmp_valid` high, the register named by `cmp_dst` is full from the next cycle. This holds even when another writer to the same register is still outstanding.
- R4: `iss_ready` is 0 exactly when at least one source whose enable bit is 1 names an empty register. A source whose enable is 0 has no effect. Source s occupies bits [5s+4:5s] of `iss_src` and bit s of `iss_src_en`.
- R5: Register 0 is always full. An accepted writer to register 0 changes nothing.
- R6: When a completion and an accepted writer name the same register in the same cycle, that register is empty in the next cycle.
- R7: An offered instruction that is refused (`iss_valid` 1, `iss_ready` 0) leaves its destination's flag unchanged.
- R8: An accepted instruction with `iss_wr_en` 0 leaves its destination's flag unchanged.
- R9: A completion affects `iss_ready` only from the cycle after the strobe, never in the same cycle.
- R10: `iss_ready` does not depend on `iss_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Decode offers an instruction |
| iss_ready | output | 1 | Offered instruction may issue |
| iss_wr_en | input | 1 | Offered instruction writes a register |
| iss_dst | input | 5 | Destination register of offered instruction |
| iss_src | input | 10 | Packed source register numbers, 5 bits each |
| iss_src_en | input | 2 | Per-source read enable |
| cmp_valid | input | 1 | A writer completes this cycle |
| cmp_dst | input | 5 | Destination register of completing writer |

## Verification
The hardest case to reach is a completion and a new accepted writer landing on the same register in the same cycle. Only the port behaviour shows which of the two won, and only if a reader probes that register afterwards. The bench first leaves a writer outstanding. It then lines up its completion with a fresh issue to that register, and in the following cycle offers a reader of it. Refused writers are reached the same way: a register is held empty, a reader of it that also writes a second register is offered, and the second register is probed afterwards. Long runs of random traffic over a narrow band of registers then produce many such collisions, and each is checked against the bench's reference model.

// File: rtl/sb_pkg.sv
package sb_pkg;
  parameter int unsigned SB_NUM_REGS = 32;
  parameter int unsigned SB_NUM_SRCS = 2;
  localparam int unsigned SB_IDX_W   = $clog2(SB_NUM_REGS);

  typedef logic [SB_IDX_W-1:0] sb_idx_t;
endpackage

// File: rtl/sb_valid_array.sv
module sb_valid_array #(
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned IDX_W = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_en,
  input  logic [IDX_W-1:0]    clr_idx,
  input  logic                set_en,
  input  logic [IDX_W-1:0]    set_idx,
  output logic [NUM_REGS-1:0] full_q
);
  // One flag per register; entry 0 is a constant full flag.
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_flag
    if (r == 0) begin : g_zero
      assign full_q[r] = 1'b1;
    end else begin : g_live
      logic hit_clr, hit_set;
      assign hit_clr = clr_en && (clr_idx == IDX_W'(r));
      assign hit_set = set_en && (set_idx == IDX_W'(r));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       full_q[r] <= 1'b1;
        else if (hit_clr) full_q[r] <= 1'b0;   // new writer beats completion
        else if (hit_set) full_q[r] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sb_src_check.sv
module sb_src_check #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned NUM_SRCS = 2,
  localparam int unsigned IDX_W = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0]       full_vec,
  input  logic [NUM_SRCS*IDX_W-1:0] src_idx,
  input  logic [NUM_SRCS-1:0]       src_en,
  output logic                      all_full
);
  logic [NUM_SRCS-1:0] blocked;

  for (genvar s = 0; s < NUM_SRCS; s++) begin : g_src
    logic [IDX_W-1:0] idx;
    assign idx        = src_idx[s*IDX_W +: IDX_W];
    assign blocked[s] = src_en[s] && !full_vec[idx];
  end

  assign all_full = ~|blocked;
endmodule

// File: rtl/reg_scoreboard.sv
module reg_scoreboard #(
  parameter int unsigned NUM_REGS = sb_pkg::SB_NUM_REGS,
  parameter int unsigned NUM_SRCS = sb_pkg::SB_NUM_SRCS,
  localparam int unsigned IDX_W = $clog2(NUM_REGS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      iss_valid,
  output logic                      iss_ready,
  input  logic                      iss_wr_en,
  input  logic [IDX_W-1:0]          iss_dst,
  input  logic [NUM_SRCS*IDX_W-1:0] iss_src,
  input  logic [NUM_SRCS-1:0]       iss_src_en,
  input  logic                      cmp_valid,
  input  logic [IDX_W-1:0]          cmp_dst
);
  logic [NUM_REGS-1:0] full_q;
  logic                src_ok;
  logic                claim;

  sb_src_check #(.NUM_REGS(NUM_REGS), .NUM_SRCS(NUM_SRCS)) u_check (
    .full_vec (full_q),
    .src_idx  (iss_src),
    .src_en   (iss_src_en),
    .all_full (src_ok)
  );

  assign iss_ready = src_ok;
  // Only an accepted writer may claim its destination.
  assign claim     = iss_valid && src_ok && iss_wr_en;

  sb_valid_array #(.NUM_REGS(NUM_REGS)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_en  (claim),
    .clr_idx (iss_dst),
    .set_en  (cmp_valid),
    .set_idx (cmp_dst),
    .full_q  (full_q)
  );
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned NUM_SRCS = 2,
  localparam int unsigned IDX_W = $clog2(NUM_REGS)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      iss_valid,
  input logic                      iss_ready,
  input logic                      iss_wr_en,
  input logic [IDX_W-1:0]          iss_dst,
  input logic [NUM_SRCS*IDX_W-1:0] iss_src,
  input logic [NUM_SRCS-1:0]       iss_src_en,
  input logic                      cmp_valid,
  input logic [IDX_W-1:0]          cmp_dst,
  input logic [NUM_REGS-1:0]       flags
);
  // R2 / R6: an accepted writer empties its destination
  p_claim_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready && iss_wr_en && iss_dst != '0) |=> !flags[$past(iss_dst)]);

  // R3: completion fills the register unless a new writer claims it
  p_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !(iss_valid && iss_ready && iss_wr_en && iss_dst == cmp_dst))
      |=> flags[$past(cmp_dst)]);

  // R5: register 0 stays full
  p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n) flags[0]);

  // R7: a refused writer leaves its destination untouched
  p_refuse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready && !(cmp_valid && cmp_dst == iss_dst))
      |=> flags[$past(iss_dst)] == $past(flags[iss_dst]));

  // R4: an enabled source on an empty register blocks issue
  p_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_src_en[0] && !flags[iss_src[IDX_W-1:0]]) |-> !iss_ready);
endmodule

bind reg_scoreboard sb_checker #(.NUM_REGS(NUM_REGS), .NUM_SRCS(NUM_SRCS)) u_sb_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .iss_valid  (iss_valid),
  .iss_ready  (iss_ready),
  .iss_wr_en  (iss_wr_en),
  .iss_dst    (iss_dst),
  .iss_src    (iss_src),
  .iss_src_en (iss_src_en),
  .cmp_valid  (cmp_valid),
  .cmp_dst    (cmp_dst),
  .flags      (full_q)
);

// File: tb/test_reg_scoreboard.sv
`timescale 1ns/100ps
module test_reg_scoreboard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       iss_valid = 1'b0;
  logic       iss_ready;
  logic       iss_wr_en = 1'b0;
  logic [4:0] iss_dst = '0;
  logic [9:0] iss_src = '0;
  logic [1:0] iss_src_en = '0;
  logic       cmp_valid = 1'b0;
  logic [4:0] cmp_dst = '0;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit model [32];   // 1 = full

  always #2.5 clk = ~clk;

  reg_scoreboard i_reg_scoreboard (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_wr_en(iss_wr_en), .iss_dst(iss_dst), .iss_src(iss_src),
    .iss_src_en(iss_src_en), .cmp_valid(cmp_valid), .cmp_dst(cmp_dst)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<50000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic bit exp_ready();
    bit r = 1'b1;
    if (iss_src_en[0] && !model[iss_src[4:0]]) r = 1'b0;
    if (iss_src_en[1] && !model[iss_src[9:5]]) r = 1'b0;
    return r;
  endfunction

  // Drive at negedge, compare before the edge, then advance the model.
  task automatic step(input string tag, input bit v, input bit wr, input int dst,
                      input int s0, input bit e0, input int s1, input bit e1,
                      input bit cv, input int cd);
    bit er;
    @(negedge clk);
    iss_valid = v; iss_wr_en = wr; iss_dst = 5'(dst);
    iss_src = {5'(s1), 5'(s0)}; iss_src_en = {e1, e0};
    cmp_valid = cv; cmp_dst = 5'(cd);
    #1;
    er = exp_ready();
    checks++;
    if (iss_ready !== er) begin
      fails++;
      $display("FAIL %s: iss_ready actual=%0b expected=%0b (src %0d/%0d)", tag, iss_ready, er, s0, s1);
    end
    @(posedge clk);
    if (cv) model[cd] = 1'b1;
    if (v && er && wr) model[dst] = 1'b0;
    model[0] = 1'b1;
  endtask

  // Probe one register's state through iss_ready, with nothing else happening.
  task automatic probe(input string tag, input int r, input bit expect_full);
    step(tag, 1'b0, 1'b0, 0, r, 1'b1, 0, 1'b0, 1'b0, 0);
    if (model[r] !== expect_full) begin
      fails++; checks++;
      $display("FAIL %s: model reg %0d actual=%0b expected=%0b", tag, r, model[r], expect_full);
    end else checks++;
  endtask

  initial begin
    foreach (model[i]) model[i] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: every register full after reset
    for (int r = 0; r < 32; r += 2)
      step("R1", 1'b0, 1'b0, 0, r, 1'b1, r + 1, 1'b1, 1'b0, 0);

    // R2 / R4: dependent pair on r5
    step("R2", 1'b1, 1'b1, 5, 1, 1'b1, 2, 1'b1, 1'b0, 0);
    step("R4", 1'b1, 1'b1, 6, 5, 1'b1, 2, 1'b1, 1'b0, 0);   // blocked
    step("R10", 1'b0, 1'b1, 6, 2, 1'b1, 5, 1'b1, 1'b0, 0);  // still low, no valid
    step("R4", 1'b1, 1'b1, 8, 1, 1'b1, 5, 1'b0, 1'b0, 0);   // disabled src ignored
    step("R9", 1'b1, 1'b1, 6, 5, 1'b1, 2, 1'b1, 1'b1, 5);   // completion same cycle
    step("R3", 1'b1, 1'b1, 6, 5, 1'b1, 2, 1'b1, 1'b0, 0);   // now issues
    probe("R3", 8, 1'b0);
    step("R3", 1'b0, 1'b0, 0, 0, 1'b0, 0, 1'b0, 1'b1, 8);
    step("R3", 1'b0, 1'b0, 0, 0, 1'b0, 0, 1'b0, 1'b1, 6);

    // Two writers to r7, one completes
    step("R2", 1'b1, 1'b1, 7, 0, 1'b1, 0, 1'b1, 1'b0, 0);
    step("R2", 1'b1, 1'b1, 7, 0, 1'b1, 0, 1'b1, 1'b0, 0);
    probe("R2", 7, 1'b0);
    step("R3", 1'b0, 1'b0, 0, 7, 1'b1, 0, 1'b0, 1'b1, 7);
    probe("R3", 7, 1'b1);

    // R6: completion and new claim of r9 together
    step("R6", 1'b1, 1'b1, 9, 1, 1'b1, 0, 1'b0, 1'b0, 0);
    step("R6", 1'b1, 1'b1, 9, 1, 1'b1, 0, 1'b0, 1'b1, 9);
    probe("R6", 9, 1'b0);
    step("R6", 1'b0, 1'b0, 0, 0, 1'b0, 0, 1'b0, 1'b1, 9);
    probe("R6", 9, 1'b1);

    // R5: writer to r0
    step("R5", 1'b1, 1'b1, 0, 3, 1'b1, 0, 1'b0, 1'b0, 0);
    probe("R5", 0, 1'b1);

    // R7: refused writer to r11 (reads empty r10)
    step("R7", 1'b1, 1'b1, 10, 0, 1'b0, 0, 1'b0, 1'b0, 0);
    step("R7", 1'b1, 1'b1, 11, 10, 1'b1, 0, 1'b0, 1'b0, 0);
    probe("R7", 11, 1'b1);
    step("R7", 1'b0, 1'b0, 0, 0, 1'b0, 0, 1'b0, 1'b1, 10);

    // R8: accepted non-writer
    step("R8", 1'b1, 1'b0, 12, 1, 1'b1, 2, 1'b1, 1'b0, 0);
    probe("R8", 12, 1'b1);

    // Random traffic on r0..r7 (R4 mostly)
    for (int n = 0; n < 2000; n++)
      step("R4", 1'($urandom), 1'($urandom), int'($urandom % 8),
           int'($urandom % 8), 1'($urandom), int'($urandom % 8), 1'($urandom),
           1'($urandom), int'($urandom % 8));

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule